// File: doc/BRIEF.md
# Twelve-Bit Reloading Up-Counter Timer

This block is a free-running 12-bit up-counter for a small controller. It sits on a simple byte-wide register bus with an address, write and read strobes, and write and read data. Software chooses how the counter advances. It can be halted, it can step on an externally supplied one-cycle timebase pulse, or it can step on every system clock. When the count leaves its all-ones value, it does not return to zero. It restarts from a software-programmed reload value and raises an overflow flag.

A separate 12-bit compare value raises a compare flag when the count reaches it. One status read clears both flags. The compare flag drops at once. The overflow flag stays visible until the next counter step after the read. Two enable bits gate the flags onto a registered interrupt line.

The count is read as two bytes. There is no shadow latch, so the high byte can advance between the two byte reads. All logic runs in one clock domain with a synchronous active-high reset.

Top module: `reload_timer12`

## Requirements
- R1: Each counter step adds one to the 12-bit count.
- R2: A step taken while the count is FFFh loads the count with the 12-bit reload value (reload low byte at address 3, bits 3:0 of address 4) instead of zero.
- R3: Status bits [4:3] select the step source: 00 halted, 01 one step per cycle with tick_i high, 10 one step per clock, 11 halted.
- R4: The wrap step of R2 sets the overflow flag, read at status (address 0) bit 2.
- R5: A status read with the overflow flag set leaves the flag reading 1 until the next counter step after that read, and the flag is 0 from that step on.
- R6: The status register keeps the written bits [4:3] and [1:0]. Bit 2 ignores writes. Bits 7:5 always read 0.
- R7: Address 1 returns count bits 7:0 and address 2 returns count bits 11:8 with bits 7:4 zero. Writes to both addresses have no effect on the count.
- R8: irq_o is a register that, one clock after the flags, equals (overflow flag AND status bit 1) OR (compare flag AND status bit 0).
- R9: A step that makes the count equal the compare value (low byte at address 5, bits 3:0 of address 6) sets the compare flag. Any status read clears it in the same clock.
- R10: Writing the reload value leaves the current count unchanged. The new value applies only at the next wrap.
- R11: After reset the count and every register read 00h and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; data appears on rdata_o after the edge |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle:
- The count holds still while the source is halted.
- The count steps by exactly one away from the all-ones value, and wraps to the reload value with the overflow flag set.
- The overflow flag never falls without a counter step.
- Reserved status bits read as zero.
- The interrupt stays low while both enables are clear.

Other behaviours only show up in the bench's scenarios:
- The exact lingering of the overflow flag across repeated status reads.
- The immediate clear of the compare flag.
- Ignored writes to the counter bytes.
- A reload change that waits for the next wrap.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_TICK = 2'b01,
    SRC_CLK  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  // register addresses
  localparam int A_STAT   = 0;
  localparam int A_CNT_LO = 1;
  localparam int A_CNT_HI = 2;
  localparam int A_RLD_LO = 3;
  localparam int A_RLD_HI = 4;
  localparam int A_CMP_LO = 5;
  localparam int A_CMP_HI = 6;

  // status bit positions
  localparam int B_SRC_LO = 3;
  localparam int B_OVF    = 2;
  localparam int B_OVFIE  = 1;
  localparam int B_CMPIE  = 0;
endpackage

// File: rtl/rtimer_step.sv
module rtimer_step
  import rtimer_pkg::*;
(
  input  src_e src_i,
  input  logic tick_i,
  output logic step_o
);
  always_comb begin
    case (src_i)
      SRC_TICK: step_o = tick_i;
      SRC_CLK:  step_o = 1'b1;
      default:  step_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtimer_counter.sv
module rtimer_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             cmp_hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    wrap_o    = step_i && (cnt_q == CNT_MAX);
    cnt_nxt   = wrap_o ? reload_i : cnt_q + CNT_W'(1);
    cmp_hit_o = step_i && (cnt_nxt == cmp_i);
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtimer_flags.sv
module rtimer_flags (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic wrap_i,
  input  logic cmp_hit_i,
  input  logic stat_rd_i,
  input  logic ovfie_i,
  input  logic cmpie_i,
  output logic ovf_o,
  output logic cmp_o,
  output logic irq_o
);
  logic ovf_q, clr_pend_q, cmp_q, irq_q;

  // overflow flag: a status read arms a clear that lands on the next step
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q      <= 1'b0;
      clr_pend_q <= 1'b0;
    end else if (wrap_i) begin
      ovf_q      <= 1'b1;
      clr_pend_q <= 1'b0;
    end else if (step_i && clr_pend_q) begin
      ovf_q      <= 1'b0;
      clr_pend_q <= 1'b0;
    end else if (stat_rd_i && ovf_q) begin
      clr_pend_q <= 1'b1;
    end
  end

  // compare flag: set wins, status read clears at once
  always_ff @(posedge clk) begin
    if (rst)            cmp_q <= 1'b0;
    else if (cmp_hit_i) cmp_q <= 1'b1;
    else if (stat_rd_i) cmp_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (ovf_q && ovfie_i) || (cmp_q && cmpie_i);
  end

  assign ovf_o = ovf_q;
  assign cmp_o = cmp_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/reload_timer12.sv
module reload_timer12
  import rtimer_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  src_e             sel_q;
  logic             ovfie_q, cmpie_q;
  logic [CNT_W-1:0] reload_q, cmp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step, wrap, cmp_hit, ovf_flag, cmp_flag;
  logic             stat_rd;
  logic [DATA_W-1:0] stat_val, rd_mux, rdata_q;
  logic             unused_wbits;

  assign stat_rd      = rd_en_i && (addr_i == ADDR_W'(A_STAT));
  assign unused_wbits = ^{wdata_i, cmp_flag};

  // control and value registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SRC_OFF;
      ovfie_q  <= 1'b0;
      cmpie_q  <= 1'b0;
      reload_q <= '0;
      cmp_q    <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_W'(A_STAT): begin
          sel_q   <= src_e'(wdata_i[B_SRC_LO +: 2]);
          ovfie_q <= wdata_i[B_OVFIE];
          cmpie_q <= wdata_i[B_CMPIE];
        end
        ADDR_W'(A_RLD_LO): reload_q[DATA_W-1:0]     <= wdata_i;
        ADDR_W'(A_RLD_HI): reload_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        ADDR_W'(A_CMP_LO): cmp_q[DATA_W-1:0]        <= wdata_i;
        ADDR_W'(A_CMP_HI): cmp_q[CNT_W-1:DATA_W]    <= wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  rtimer_step u_step (
    .src_i  (sel_q),
    .tick_i (tick_i),
    .step_o (step)
  );

  rtimer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .reload_i  (reload_q),
    .cmp_i     (cmp_q),
    .cnt_o     (cnt_q),
    .wrap_o    (wrap),
    .cmp_hit_o (cmp_hit)
  );

  rtimer_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .wrap_i    (wrap),
    .cmp_hit_i (cmp_hit),
    .stat_rd_i (stat_rd),
    .ovfie_i   (ovfie_q),
    .cmpie_i   (cmpie_q),
    .ovf_o     (ovf_flag),
    .cmp_o     (cmp_flag),
    .irq_o     (irq_o)
  );

  always_comb begin
    stat_val                = '0;
    stat_val[B_SRC_LO +: 2] = sel_q;
    stat_val[B_OVF]         = ovf_flag;
    stat_val[B_OVFIE]       = ovfie_q;
    stat_val[B_CMPIE]       = cmpie_q;
    case (addr_i)
      ADDR_W'(A_STAT):   rd_mux = stat_val;
      ADDR_W'(A_CNT_LO): rd_mux = cnt_q[DATA_W-1:0];
      ADDR_W'(A_CNT_HI): rd_mux = {{PAD_W{1'b0}}, cnt_q[CNT_W-1:DATA_W]};
      ADDR_W'(A_RLD_LO): rd_mux = reload_q[DATA_W-1:0];
      ADDR_W'(A_RLD_HI): rd_mux = {{PAD_W{1'b0}}, reload_q[CNT_W-1:DATA_W]};
      ADDR_W'(A_CMP_LO): rd_mux = cmp_q[DATA_W-1:0];
      ADDR_W'(A_CMP_HI): rd_mux = {{PAD_W{1'b0}}, cmp_q[CNT_W-1:DATA_W]};
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [1:0]        src_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic              ovf_q,
  input logic              ovfie_q,
  input logic              cmpie_q
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic moving;
  assign moving = (src_q == 2'b10) || (src_q == 2'b01 && tick_i);

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (src_q == 2'b00 || src_q == 2'b11) |=> $stable(cnt_q)); // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (moving && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R1

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (moving && cnt_q == TOP) |=> (cnt_q == $past(reload_q)) && ovf_q); // R2

  AST_FLAG_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !moving) |=> ovf_q); // R5

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == '0) |=> rdata_o[DATA_W-1:5] == '0); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!ovfie_q && !cmpie_q) |=> !irq_o); // R8
endmodule

bind reload_timer12 rtimer_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_i   (tick_i),
  .addr_i   (addr_i),
  .rd_en_i  (rd_en_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .src_q    (sel_q),
  .cnt_q    (cnt_q),
  .reload_q (reload_q),
  .ovf_q    (ovf_flag),
  .ovfie_q  (ovfie_q),
  .cmpie_q  (cmpie_q)
);

// File: tb/test_reload_timer12.sv
module test_reload_timer12;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  reload_timer12 i_reload_timer12 (
    .clk(clk), .rst(rst), .tick_i(tick), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = 3'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); addr = 3'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) begin
      rd(a, rv); check("R11 register after reset", 12'(rv), 12'h000);
    end
    check("R11 irq after reset", 12'(irq), 12'h0);
  endtask

  task automatic t_status_fields;
    wr(0, 8'hFF); rd(0, rv); check("R6 status write mask", 12'(rv), 12'h01B);
    pulse(3); idle(4); rd(1, rv); check("R3 source 11 halted", 12'(rv), 12'h000);
    wr(0, 8'h00); pulse(3); rd(1, rv); check("R3 source 00 halted", 12'(rv), 12'h000);
  endtask

  task automatic t_tick_count;
    wr(0, 8'h08); idle(6); rd(1, rv); check("R3 no step without tick", 12'(rv), 12'h000);
    pulse(5); rd(1, rv); check("R1 five steps", 12'(rv), 12'h005);
    wr(1, 8'hAA); wr(2, 8'h07);
    rd(1, rv); check("R7 count low write ignored", 12'(rv), 12'h005);
    rd(2, rv); check("R7 count high write ignored", 12'(rv), 12'h000);
    wr(3, 8'h23); wr(4, 8'h01);
    rd(1, rv); check("R10 reload write keeps count", 12'(rv), 12'h005);
    rd(3, rv); check("R10 reload low readback", 12'(rv), 12'h023);
  endtask

  task automatic t_wrap;
    pulse(4090);
    rd(1, rv); check("R7 low byte at top", 12'(rv), 12'h0FF);
    rd(2, rv); check("R7 high byte at top", 12'(rv), 12'h00F);
    rd(0, rv); check("R4 no flag before wrap", 12'(rv), 12'h008);
    pulse(1);
    rd(1, rv); check("R2 wrap low byte", 12'(rv), 12'h023);
    rd(2, rv); check("R2 wrap high byte", 12'(rv), 12'h001);
    rd(0, rv); check("R4 flag after wrap", 12'(rv), 12'h00C);
    rd(0, rv); check("R5 flag lingers after read", 12'(rv), 12'h00C);
    pulse(1);
    rd(0, rv); check("R5 flag gone after step", 12'(rv), 12'h008);
  endtask

  task automatic t_irq;
    wr(3, 8'hFE); wr(4, 8'h0F);
    pulse(3803 + 1);
    rd(1, rv); check("R2 wrap to new reload", 12'(rv), 12'h0FE);
    idle(2); check("R8 irq masked", 12'(irq), 12'h0);
    wr(0, 8'h0A); idle(2); check("R8 irq on overflow", 12'(irq), 12'h1);
    rd(0, rv); check("R4 status with flag and enable", 12'(rv), 12'h00E);
    idle(2); check("R5 irq held until step", 12'(irq), 12'h1);
    pulse(1); idle(2); check("R8 irq drops with flag", 12'(irq), 12'h0);
  endtask

  task automatic t_compare;
    wr(3, 8'h10); wr(4, 8'h00); wr(5, 8'h13); wr(6, 8'h00); wr(0, 8'h09);
    pulse(1); idle(2); check("R8 overflow masked under compare enable", 12'(irq), 12'h0);
    pulse(2); idle(2); check("R9 no compare before match", 12'(irq), 12'h0);
    pulse(1); idle(2); check("R9 compare raises irq", 12'(irq), 12'h1);
    rd(1, rv); check("R9 count at compare", 12'(rv), 12'h013);
    rd(0, rv); idle(2); check("R9 compare cleared by read", 12'(irq), 12'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_status_fields;
    t_tick_count;
    t_wrap;
    t_irq;
    t_compare;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule